// File: doc/BRIEF.md
# Byte-wide SPI master controller

This block is an SPI master that exchanges one byte per command and has no FIFO. Software reaches it through a small register file on a synchronous byte bus with an address, a write strobe and a read strobe. To send a byte, software loads the transmit register and writes the start bit. The block then drives eight bits out on `mosi` and captures eight bits from `miso`, or from its own output when internal loopback is selected. The received byte is then posted to the receive register, a ready flag is set, and `irq` is raised.

Clock polarity, the latch edge and the bit order come from the mode register. They are captured when a transfer begins. The serial clock period is 4×(D+1) bus clocks, where D is the 8-bit divisor. Each byte needs a new transmit write (when its value changes) and a new start. Chip select is handled outside the block.

A three-state engine sequences each transfer:
- `ST_IDLE` moves to `ST_SHIFT` on an accepted start.
- `ST_SHIFT` moves to `ST_FINISH` on the sixteenth serial clock edge. Ready and `irq` rise on that same edge.
- `ST_FINISH` always returns to `ST_IDLE` one cycle later. Busy clears at that point.

Top module: `spi_byte_master`

## Requirements
- R1: After reset, status (offset 4) reads 0x00. The receive register (offset 1) reads 0x00, and `irq`, `sck` and `mosi` are low.
- R2: The register offsets are: mode 0, receive 1, transmit 2, command 3, status 4, divisor 6. Mode reads back its low five bits. Transmit and divisor read back in full. Offsets 3, 5 and 7 read 0x00.
- R3: Mode bits: 0x10 selects leading-edge latching, 0x08 enables the port, 0x04 selects LSB-first, 0x02 sets the clock idle level high, and 0x01 selects loopback. Outside a transfer, `sck` rests at the idle level.
- R4: Writing a value with bit 0 set to offset 3 starts a transfer when the port is enabled and idle. A transfer gives exactly 16 `sck` edges and exchanges one byte.
- R5: With 0x10 set, `miso` is sampled on leading edges and `mosi` changes on trailing edges. With 0x10 clear, `mosi` changes on leading edges and `miso` is sampled on trailing edges.
- R6: With 0x04 clear, bit 7 is sent and received first. With 0x04 set, bit 0 is sent and received first.
- R7: Each `sck` half period lasts 2×(D+1) bus clocks, where D is the divisor register value.
- R8: On the final edge, status bit 0x01 (ready) and `irq` rise while status bit 0x02 (busy) is still set. Busy clears exactly one cycle later.
- R9: Reading offset 1 clears ready and `irq`. An accepted start also clears them.
- R10: With 0x08 clear, start writes are ignored, `mosi` stays low and `sck` stays at the idle level.
- R11: With 0x01 set, the received byte equals the transmitted byte whatever `miso` carries.
- R12: A start written while busy is ignored. A transmit write during a transfer does not change the byte being shifted, but it is used by the next start.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_addr | input | 3 | Register offset |
| bus_wdata | input | 8 | Write data |
| bus_we | input | 1 | Write strobe, one cycle per write |
| bus_re | input | 1 | Read strobe, clears ready when addressing offset 1 |
| bus_rdata | output | 8 | Read data for `bus_addr`, combinational |
| irq | output | 1 | Byte-complete interrupt, equal to ready |
| sck | output | 1 | Serial clock |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |

## Verification
The hardest cycle to reach is the single cycle between completion and the clearing of busy, when status reads 0x03. The bench polls `irq` on every falling clock edge and reads status combinationally in that same half cycle, then again one cycle later. Start-while-busy is reached by letting a transfer run part way before writing new transmit data and a second start. The bench then confirms that the original byte completes after exactly 16 edges and that the new byte goes out on the following start. A bus-cycle-driven slave model in the bench follows the latch edge and bit order on its own, so phase and ordering errors show up as wrong bytes on either side.

// File: rtl/spibm_pkg.sv
package spibm_pkg;

    localparam int BYTE_W = 8;
    localparam int OFFS_W = 3;
    localparam int DIVR_W = 8;

    localparam logic [OFFS_W-1:0] OFF_MODE = 3'd0;
    localparam logic [OFFS_W-1:0] OFF_RX   = 3'd1;
    localparam logic [OFFS_W-1:0] OFF_TX   = 3'd2;
    localparam logic [OFFS_W-1:0] OFF_CMD  = 3'd3;
    localparam logic [OFFS_W-1:0] OFF_STAT = 3'd4;
    localparam logic [OFFS_W-1:0] OFF_DIV  = 3'd6;

    // Field order matches the mode register bits 4 down to 0.
    typedef struct packed {
        logic lead;   // 0x10: latch on leading edge
        logic en;     // 0x08: port enable
        logic lsb;    // 0x04: LSB first
        logic idle;   // 0x02: clock idle level
        logic loop;   // 0x01: internal loopback
    } mode_t;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_SHIFT  = 2'd1,
        ST_FINISH = 2'd2
    } eng_state_t;

endpackage

// File: rtl/spibm_clkdiv.sv
module spibm_clkdiv #(
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [DIV_W-1:0] div,
    output logic             tick
);
    localparam int CW = DIV_W + 1;

    logic [CW-1:0] cnt_q;
    logic [CW-1:0] lim;

    // Half period of the serial clock is 2*(div+1) cycles.
    assign lim  = {div, 1'b1};
    assign tick = run && (cnt_q == lim);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (!run || tick) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end
endmodule

// File: rtl/spibm_regs.sv
module spibm_regs
    import spibm_pkg::*;
#(
    parameter int BITS   = 8,
    parameter int ADDR_W = 3,
    parameter int DIV_W  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [BITS-1:0]   bus_wdata,
    input  logic              bus_we,
    input  logic              bus_re,
    output logic [BITS-1:0]   bus_rdata,
    input  logic              busy,
    input  logic              done,
    input  logic [BITS-1:0]   rx_byte,
    output mode_t             mode,
    output logic [BITS-1:0]   tx_byte,
    output logic [DIV_W-1:0]  div,
    output logic              start,
    output logic              ready
);
    localparam int MODE_W = $bits(mode_t);

    mode_t             mode_q;
    logic [BITS-1:0]   tx_q;
    logic [DIV_W-1:0]  div_q;
    logic              ready_q;
    logic              rx_rd;

    assign start = bus_we && (bus_addr == OFF_CMD) && bus_wdata[0]
                   && mode_q.en && !busy;
    assign rx_rd = bus_re && (bus_addr == OFF_RX);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mode_q <= '0;
            tx_q   <= '0;
            div_q  <= '0;
        end else if (bus_we) begin
            if (bus_addr == OFF_MODE) mode_q <= mode_t'(bus_wdata[MODE_W-1:0]);
            if (bus_addr == OFF_TX)   tx_q   <= bus_wdata;
            if (bus_addr == OFF_DIV)  div_q  <= bus_wdata[DIV_W-1:0];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ready_q <= 1'b0;
        end else if (done) begin
            ready_q <= 1'b1;
        end else if (rx_rd || start) begin
            ready_q <= 1'b0;
        end
    end

    always_comb begin
        bus_rdata = '0;
        case (bus_addr)
            OFF_MODE: bus_rdata = BITS'(mode_q);
            OFF_RX:   bus_rdata = rx_byte;
            OFF_TX:   bus_rdata = tx_q;
            OFF_STAT: bus_rdata = BITS'({busy, ready_q});
            OFF_DIV:  bus_rdata = BITS'(div_q);
            default:  bus_rdata = '0;
        endcase
    end

    assign mode    = mode_q;
    assign tx_byte = tx_q;
    assign div     = div_q;
    assign ready   = ready_q;
endmodule

// File: rtl/spibm_engine.sv
module spibm_engine
    import spibm_pkg::*;
#(
    parameter int BITS = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            start,
    input  logic            tick,
    input  mode_t           mode,
    input  logic [BITS-1:0] tx_byte,
    input  logic            miso,
    output logic            sck,
    output logic            mosi,
    output logic            busy,
    output logic            shifting,
    output logic            done,
    output logic [BITS-1:0] rx_byte
);
    localparam int EDGES = 2 * BITS;
    localparam int EW    = $clog2(EDGES);
    localparam logic [EW-1:0] LAST_EDGE = EW'(EDGES - 1);

    eng_state_t      state_q, state_d;
    mode_t           cfg_q;
    logic [EW-1:0]   edge_q;
    logic [BITS-1:0] tx_sh, rx_sh, rx_q;
    logic [BITS-1:0] tx_ord, rx_next, rx_rev;
    logic            out_q, sck_q;
    logic            cpha, is_sample, is_shift, in_bit, last_tick;

    assign cpha      = ~cfg_q.lead;
    assign is_sample = (edge_q[0] == cpha);
    assign is_shift  = !is_sample
                       && !(!cpha && edge_q == LAST_EDGE)
                       && !( cpha && edge_q == '0);
    assign in_bit    = cfg_q.loop ? out_q : miso;
    assign rx_next   = is_sample ? {rx_sh[BITS-2:0], in_bit} : rx_sh;
    assign last_tick = tick && (edge_q == LAST_EDGE);

    always_comb begin
        for (int i = 0; i < BITS; i++) begin
            tx_ord[i] = mode.lsb ? tx_byte[BITS-1-i] : tx_byte[i];
            rx_rev[i] = rx_next[BITS-1-i];
        end
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   if (start)     state_d = ST_SHIFT;
            ST_SHIFT:  if (last_tick) state_d = ST_FINISH;
            ST_FINISH:                state_d = ST_IDLE;
            default:                  state_d = ST_IDLE;
        endcase
    end

    // Output and datapath process
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cfg_q  <= '0;
            edge_q <= '0;
            tx_sh  <= '0;
            rx_sh  <= '0;
            rx_q   <= '0;
            out_q  <= 1'b0;
            sck_q  <= 1'b0;
        end else begin
            unique case (state_q)
                ST_IDLE: begin
                    sck_q <= mode.idle;
                    if (start) begin
                        cfg_q  <= mode;
                        tx_sh  <= tx_ord;
                        out_q  <= tx_ord[BITS-1];
                        rx_sh  <= '0;
                        edge_q <= '0;
                    end
                end
                ST_SHIFT: begin
                    if (tick) begin
                        sck_q  <= ~sck_q;
                        edge_q <= edge_q + 1'b1;
                        rx_sh  <= rx_next;
                        if (is_shift) begin
                            out_q <= tx_sh[BITS-2];
                            tx_sh <= {tx_sh[BITS-2:0], 1'b0};
                        end
                        if (edge_q == LAST_EDGE) begin
                            rx_q <= cfg_q.lsb ? rx_rev : rx_next;
                        end
                    end
                end
                ST_FINISH: begin
                    sck_q <= cfg_q.idle;
                end
                default: ;
            endcase
        end
    end

    assign sck      = sck_q;
    assign mosi     = mode.en ? out_q : 1'b0;
    assign busy     = (state_q != ST_IDLE);
    assign shifting = (state_q == ST_SHIFT);
    assign done     = shifting && last_tick;
    assign rx_byte  = rx_q;
endmodule

// File: rtl/spi_byte_master.sv
module spi_byte_master
    import spibm_pkg::*;
#(
    parameter int BITS   = BYTE_W,
    parameter int ADDR_W = OFFS_W,
    parameter int DIV_W  = DIVR_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [BITS-1:0]   bus_wdata,
    input  logic              bus_we,
    input  logic              bus_re,
    output logic [BITS-1:0]   bus_rdata,
    output logic              irq,
    output logic              sck,
    output logic              mosi,
    input  logic              miso
);
    mode_t            cur_mode;
    logic [BITS-1:0]  tx_byte, rx_byte;
    logic [DIV_W-1:0] div;
    logic             start, ready, eng_busy, eng_shifting, eng_done, tick;
    logic             port_en;

    assign port_en = cur_mode.en;

    spibm_regs #(.BITS(BITS), .ADDR_W(ADDR_W), .DIV_W(DIV_W)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_we    (bus_we),
        .bus_re    (bus_re),
        .bus_rdata (bus_rdata),
        .busy      (eng_busy),
        .done      (eng_done),
        .rx_byte   (rx_byte),
        .mode      (cur_mode),
        .tx_byte   (tx_byte),
        .div       (div),
        .start     (start),
        .ready     (ready)
    );

    spibm_clkdiv #(.DIV_W(DIV_W)) u_div (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (eng_shifting),
        .div   (div),
        .tick  (tick)
    );

    spibm_engine #(.BITS(BITS)) u_eng (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (start),
        .tick     (tick),
        .mode     (cur_mode),
        .tx_byte  (tx_byte),
        .miso     (miso),
        .sck      (sck),
        .mosi     (mosi),
        .busy     (eng_busy),
        .shifting (eng_shifting),
        .done     (eng_done),
        .rx_byte  (rx_byte)
    );

    assign irq = ready;
endmodule

// File: rtl/spibm_checker.sv
module spibm_checker
    import spibm_pkg::*;
#(
    parameter int ADDR_W = 3
) (
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] bus_addr,
    input logic              cmd_bit,
    input logic              bus_we,
    input logic              bus_re,
    input logic              irq,
    input logic              mosi,
    input logic              busy,
    input logic              en
);
    assert_irq_while_busy_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq) |-> busy);

    assert_busy_drops_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq) |=> !busy);

    assert_mosi_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !en |-> !mosi);

    assert_rx_read_clears_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_re && bus_addr == OFF_RX && !busy) |=> !irq);

    assert_start_accepted_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && bus_addr == OFF_CMD && cmd_bit && en && !busy) |=> busy);

    assert_start_clears_ready_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> !irq);
endmodule

bind spi_byte_master spibm_checker #(.ADDR_W(ADDR_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .bus_addr (bus_addr),
    .cmd_bit  (bus_wdata[0]),
    .bus_we   (bus_we),
    .bus_re   (bus_re),
    .irq      (irq),
    .mosi     (mosi),
    .busy     (eng_busy),
    .en       (port_en)
);

// File: tb/spi_byte_master_bench.sv
`timescale 1ns/1ps
module spi_byte_master_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [2:0] bus_addr = '0;
    logic [7:0] bus_wdata = '0;
    logic       bus_we = 1'b0;
    logic       bus_re = 1'b0;
    logic [7:0] bus_rdata;
    logic       irq, sck, mosi;
    logic       miso = 1'b0;

    always #2.5 clk = ~clk;

    spi_byte_master u_spi_byte_master (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_we(bus_we), .bus_re(bus_re), .bus_rdata(bus_rdata),
        .irq(irq), .sck(sck), .mosi(mosi), .miso(miso)
    );

    int cyc = 0;
    int n_checks = 0;
    int n_fail = 0;
    always @(posedge clk) cyc++;

    // Slave model, evaluated just after each rising bus clock edge.
    logic       s_arm = 1'b0, s_cpol = 1'b0, s_cpha = 1'b0, s_lsb = 1'b0;
    logic [7:0] s_tx = '0, s_rx = '0;
    logic       s_prev = 1'b0;
    int         s_edges = 0, s_ncap = 0, s_t0 = 0, s_t1 = 0;

    always @(posedge clk) begin
        #1;
        if (s_arm) begin
            s_prev  = sck;
            s_edges = 0;
            s_ncap  = 0;
            s_rx    = '0;
            miso    = s_tx[s_lsb ? 0 : 7];
        end else if (sck !== s_prev) begin
            logic lead_e, samp;
            s_prev = sck;
            if (s_edges == 0) s_t0 = cyc;
            if (s_edges == 1) s_t1 = cyc;
            s_edges++;
            lead_e = (sck != s_cpol);
            samp   = lead_e ^ s_cpha;
            if (samp && s_ncap < 8) begin
                s_rx[s_lsb ? s_ncap : 7 - s_ncap] = mosi;
                s_ncap++;
                if (s_ncap < 8) miso = s_tx[s_lsb ? s_ncap : 7 - s_ncap];
            end
        end
    end

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_we = 1'b1;
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [7:0] v);
        @(negedge clk);
        bus_addr = a; bus_re = 1'b1;
        #1 v = bus_rdata;
        @(negedge clk);
        bus_re = 1'b0;
    endtask

    task automatic peek(input logic [2:0] a, output logic [7:0] v);
        bus_addr = a;
        #1 v = bus_rdata;
    endtask

    task automatic arm(input logic [4:0] md, input logic [7:0] stx);
        @(negedge clk);
        s_cpol = md[1]; s_cpha = !md[4]; s_lsb = md[2]; s_tx = stx; s_arm = 1'b1;
        @(negedge clk);
        s_arm = 1'b0;
    endtask

    task automatic wait_irq();
        int n = 0;
        while (irq !== 1'b1 && n < 20000) begin
            @(negedge clk);
            n++;
        end
    endtask

    task automatic xfer(input logic [4:0] md, input logic [7:0] dv, input logic [7:0] txb,
                        input logic [7:0] stx, input string tag);
        logic [7:0] v;
        wr(3'd0, {3'b0, md});
        wr(3'd6, dv);
        wr(3'd2, txb);
        arm(md, stx);
        wr(3'd3, 8'h01);
        wait_irq();
        peek(3'd4, v);
        check("R8 busy+ready at irq", v, 8'h03);
        @(negedge clk);
        peek(3'd4, v);
        check("R8 busy cleared", v, 8'h01);
        rd(3'd1, v);
        check({tag, " received byte"}, v, md[0] ? txb : stx);
        check({tag, " slave capture"}, s_rx, txb);
        check("R4 edge count", s_edges, 16);
        check("R7 half period", s_t1 - s_t0, 2 * (dv + 1));
        peek(3'd4, v);
        check("R9 read clears ready", {irq, v}, 9'h000);
    endtask

    initial begin : watchdog
        wait (cyc >= 190000);
        n_fail++;
        $display("FAIL watchdog: actual %0d expected below 190000", cyc);
        $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end

    initial begin : main
        logic [7:0] v;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        peek(3'd4, v); check("R1 status", v, 8'h00);
        peek(3'd1, v); check("R1 rx", v, 8'h00);
        check("R1 pins", {irq, sck, mosi}, 3'b000);

        // R2 register map
        wr(3'd0, 8'hFF); peek(3'd0, v); check("R2 mode readback", v, 8'h1F);
        wr(3'd6, 8'hA5); peek(3'd6, v); check("R2 divisor readback", v, 8'hA5);
        wr(3'd2, 8'h3C); peek(3'd2, v); check("R2 tx readback", v, 8'h3C);
        peek(3'd3, v); check("R2 command reads zero", v, 8'h00);
        peek(3'd5, v); check("R2 spare reads zero", v, 8'h00);
        peek(3'd7, v); check("R2 top offset reads zero", v, 8'h00);

        // R3 idle level follows mode
        wr(3'd0, 8'h0A); @(negedge clk); check("R3 idle high", sck, 1'b1);
        wr(3'd0, 8'h08); @(negedge clk); check("R3 idle low", sck, 1'b0);

        // R10 disabled port ignores start
        wr(3'd0, 8'h02); wr(3'd2, 8'hFF); arm(5'h02, 8'h00);
        wr(3'd3, 8'h01);
        repeat (40) @(negedge clk);
        peek(3'd4, v); check("R10 status stays zero", v, 8'h00);
        check("R10 pins", {irq, sck, mosi}, 3'b010);
        check("R10 no edges", s_edges, 0);

        // R4 R5 R6 sweep over phase, polarity and order
        for (int c = 0; c < 8; c++) begin
            logic [4:0] md;
            md = 5'h08 | (c[0] ? 5'h10 : 5'h0) | (c[1] ? 5'h02 : 5'h0) | (c[2] ? 5'h04 : 5'h0);
            for (int x = 0; x < 256; x += (c == 0) ? 1 : 9) begin
                xfer(md, 8'd0, 8'(x), 8'((x * 37 + 11) % 256), c[2] ? "R6" : "R5");
            end
        end

        // R11 loopback ignores miso
        for (int c = 0; c < 8; c++) begin
            logic [4:0] md;
            md = 5'h09 | (c[0] ? 5'h10 : 5'h0) | (c[1] ? 5'h02 : 5'h0) | (c[2] ? 5'h04 : 5'h0);
            for (int x = 3; x < 256; x += 17) begin
                xfer(md, 8'd0, 8'(x), ~8'(x), "R11");
            end
        end

        // R7 divisor values
        xfer(5'h18, 8'd1, 8'h96, 8'h69, "R7");
        xfer(5'h1A, 8'd3, 8'h0F, 8'hF0, "R7");
        xfer(5'h08, 8'd255, 8'hC3, 8'h81, "R7");

        // R12 start during a transfer is ignored; tx write waits for next start
        wr(3'd0, 8'h18); wr(3'd6, 8'd3); wr(3'd2, 8'hA5);
        arm(5'h18, 8'h3C);
        wr(3'd3, 8'h01);
        repeat (30) @(negedge clk);
        wr(3'd2, 8'h5A);
        wr(3'd3, 8'h01);
        peek(3'd4, v); check("R12 still busy mid-transfer", v[1], 1'b1);
        wait_irq();
        @(negedge clk);
        rd(3'd1, v); check("R12 rx of first byte", v, 8'h3C);
        check("R12 shifted byte unchanged", s_rx, 8'hA5);
        check("R12 no restart", s_edges, 16);
        arm(5'h18, 8'h77);
        wr(3'd3, 8'h01);
        wait_irq();
        @(negedge clk);
        check("R12 next start sends new tx", s_rx, 8'h5A);

        // R9 start clears pending ready
        check("R9 ready pending", irq, 1'b1);
        arm(5'h18, 8'h11);
        wr(3'd3, 8'h01);
        peek(3'd4, v); check("R9 start clears ready", {irq, v}, 9'h002);
        wait_irq();
        @(negedge clk);
        rd(3'd1, v); check("R9 second rx", v, 8'h11);

        $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end
endmodule